// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block supplies the byte a flash-style memory returns on reads while an internal program or erase is running, or while an erase is still gathering sectors. A command decoder tells it when an operation is accepted (`op_start`) and whether it is an erase. For a program it also gives bit 7 of the byte being written and says whether the target is write-protected. The engine reports completion through `op_done` and the end of the sector-gathering window through `erase_go`. Every read the host makes while status is shown arrives as one `rd_strobe` cycle.

When `status_act` is high, the surrounding read path returns `status_q` instead of array data. When it is low, normal array reads resume.

`status_q` carries four status bits:
- bit 7 is the polling bit: the inverse of the written bit while a program runs, and 0 during an erase.
- bit 6 flips on every read.
- bit 5 is a failure flag that stays set until a reset command.
- bit 3 is 0 while more sectors may still be queued and 1 once erasing has begun.

The other bits read 0. A busy operation that runs for `PULSE_LIMIT` cycles without finishing becomes a failure. A protected target keeps status active for a fixed guard interval and then releases it without touching the array.

The state machine has six states:
- IDLE: no status is shown.
- WINDOW: the erase-gathering window.
- PROG: a program is running.
- ERASE: an erase is running.
- GUARD: the protected-target hold.
- FAULT: the pulse limit was exceeded.

Its transitions are:
- IDLE→WINDOW on an erase start.
- IDLE→PROG on an unprotected program start.
- IDLE→GUARD on a protected program start.
- WINDOW→ERASE on `erase_go` when the target is not protected.
- WINDOW→GUARD on `erase_go` when the target is protected.
- WINDOW→IDLE on `rst_cmd`.
- PROG/ERASE→IDLE on `op_done`.
- PROG/ERASE→FAULT when the limit expires.
- GUARD→IDLE when the guard count expires.
- FAULT→IDLE on `rst_cmd`.

Top module: `opstat_reporter`

## Requirements
- R1: After reset, `status_act` is 0 and `status_q` is 8'h00. Whenever no operation is active, `status_q` is 8'h00 and `status_act` is 0.
- R2: While a program runs (unprotected), `status_q[7]` equals the inverse of `prog_msb` captured at acceptance. `status_q[5]` and `status_q[3]` are 0, as are `status_q[4]` and `status_q[2:0]`.
- R3: While an erase runs (after `erase_go`), `status_q[7]` is 0 and `status_q[3]` is 1. Bit 3 does not return to 0 while status stays active.
- R4: In the erase window, `status_q[7]` and `status_q[3]` are 0. `rst_cmd` returns the block to IDLE. `erase_go` starts the erase, and wins if it arrives in the same cycle as `rst_cmd`.
- R5: `status_q[6]` is 0 right after an operation is accepted. It flips after every cycle in which `rd_strobe` is high while status is active, and holds otherwise.
- R6: `op_done` during PROG or ERASE drops `status_act` on the next cycle. This holds even when it arrives in the same cycle the pulse limit would expire.
- R7: A program or erase still busy after `PULSE_LIMIT` cycles enters FAULT. There `status_q[5]` is 1, bits 7 and 3 keep their operation's meaning, and bit 6 keeps flipping on reads. It stays there, ignoring `op_done`, until `rst_cmd`.
- R8: A program to a protected target shows program status for exactly `PROG_GUARD_CYC` cycles and then releases, whatever `op_done` does.
- R9: An erase whose targets are all protected shows erase status (bit 7 = 0, bit 3 = 1) for exactly `ERASE_GUARD_CYC` cycles after `erase_go`, then releases.
- R10: While status is active, `op_start` is ignored. In PROG, ERASE and GUARD, `rst_cmd` is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Operation accepted by the command decoder (one cycle) |
| op_is_erase | input | 1 | 1 = erase, 0 = program; sampled with `op_start` |
| prog_msb | input | 1 | Bit 7 of the byte being programmed; sampled with `op_start` |
| target_locked | input | 1 | Target (or every selected sector) is protected; sampled with `op_start` |
| erase_go | input | 1 | Erase-gathering window has closed; erasing begins |
| op_done | input | 1 | Engine reports completion |
| rd_strobe | input | 1 | One cycle per host read |
| rst_cmd | input | 1 | Reset command written |
| status_act | output | 1 | Status byte replaces array data |
| status_q | output | 8 | Status byte |

## Verification
Two pairs of events can land in the same cycle.

The first pair is `op_done` and pulse-limit expiry. The bench issues a program, idles for exactly `PULSE_LIMIT-1` cycles, then raises `op_done`. It expects the block to release rather than enter FAULT.

The second pair is `erase_go` and `rst_cmd` inside the erase window. The bench raises both together and expects erase status with bit 3 set, not a return to idle.

Thousands of random cycles then hit the same races by chance, and a cycle model in the bench judges every one.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_PROG,
        ST_ERASE,
        ST_GUARD,
        ST_FAULT
    } opst_e;
endpackage

// File: rtl/opstat_fsm.sv
module opstat_fsm
    import opstat_pkg::*;
#(
    parameter int PULSE_LIMIT     = 40,
    parameter int PROG_GUARD_CYC  = 16,
    parameter int ERASE_GUARD_CYC = 48
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  op_start,
    input  logic  op_is_erase,
    input  logic  prog_msb,
    input  logic  target_locked,
    input  logic  erase_go,
    input  logic  op_done,
    input  logic  rst_cmd,
    output opst_e state_q,
    output logic  accept,
    output logic  erase_q,
    output logic  msb_q
);
    localparam int GMAX = (PROG_GUARD_CYC > ERASE_GUARD_CYC) ? PROG_GUARD_CYC : ERASE_GUARD_CYC;
    localparam int MAXC = (PULSE_LIMIT > GMAX) ? PULSE_LIMIT : GMAX;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_LIMIT - 1);
    localparam logic [CW-1:0] PG_LAST    = CW'(PROG_GUARD_CYC - 1);
    localparam logic [CW-1:0] EG_LAST    = CW'(ERASE_GUARD_CYC - 1);

    opst_e         state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          locked_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    accept  = 1'b1;
                    cnt_d   = '0;
                    state_d = op_is_erase ? ST_WINDOW : (target_locked ? ST_GUARD : ST_PROG);
                end
            end
            ST_WINDOW: begin
                if (erase_go) begin
                    cnt_d   = '0;
                    state_d = locked_q ? ST_GUARD : ST_ERASE;
                end else if (rst_cmd) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (op_done)                 state_d = ST_IDLE;
                else if (cnt_q == PULSE_LAST) state_d = ST_FAULT;
                else                          cnt_d   = cnt_q + 1'b1;
            end
            ST_GUARD: begin
                if (cnt_q == (erase_q ? EG_LAST : PG_LAST)) state_d = ST_IDLE;
                else                                        cnt_d   = cnt_q + 1'b1;
            end
            ST_FAULT: begin
                if (rst_cmd) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            erase_q  <= 1'b0;
            locked_q <= 1'b0;
            msb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                erase_q  <= op_is_erase;
                locked_q <= target_locked;
                msb_q    <= prog_msb;
            end
        end
    end

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && !rst_cmd) |=> state_q == ST_FAULT); // R7
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PROG || state_q == ST_ERASE) && op_done) |=> state_q == ST_IDLE); // R6
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG || state_q == ST_ERASE) |-> cnt_q < CW'(PULSE_LIMIT)); // R7
    AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PROG || state_q == ST_ERASE) && !op_done && cnt_q != PULSE_LAST)
        |=> state_q == $past(state_q)); // R10
endmodule

// File: rtl/opstat_tgl.sv
module opstat_tgl (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic active,
    input  logic rd_strobe,
    output logic tgl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tgl_q <= 1'b0;
        else if (accept)             tgl_q <= 1'b0;
        else if (active && rd_strobe) tgl_q <= ~tgl_q;
    end

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_strobe) |=> tgl_q != $past(tgl_q)); // R5
    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !accept) |=> $stable(tgl_q)); // R5
endmodule

// File: rtl/opstat_enc.sv
module opstat_enc
    import opstat_pkg::*;
(
    input  opst_e      state_q,
    input  logic       erase_q,
    input  logic       msb_q,
    input  logic       tgl_q,
    output logic       status_act,
    output logic [7:0] status_q
);
    // output process
    always_comb begin
        status_act = 1'b0;
        status_q   = 8'h00;
        unique case (state_q)
            ST_IDLE: ;
            ST_WINDOW: begin
                status_act  = 1'b1;
                status_q[6] = tgl_q;
            end
            ST_PROG, ST_ERASE, ST_GUARD, ST_FAULT: begin
                status_act  = 1'b1;
                status_q[7] = erase_q ? 1'b0 : ~msb_q;
                status_q[6] = tgl_q;
                status_q[5] = (state_q == ST_FAULT);
                status_q[3] = erase_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
    import opstat_pkg::*;
#(
    parameter int PULSE_LIMIT     = 40,
    parameter int PROG_GUARD_CYC  = 16,
    parameter int ERASE_GUARD_CYC = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic       op_is_erase,
    input  logic       prog_msb,
    input  logic       target_locked,
    input  logic       erase_go,
    input  logic       op_done,
    input  logic       rd_strobe,
    input  logic       rst_cmd,
    output logic       status_act,
    output logic [7:0] status_q
);
    opst_e state_q;
    logic  accept, erase_q, msb_q, tgl_q, active;

    assign active = (state_q != ST_IDLE);

    opstat_fsm #(
        .PULSE_LIMIT    (PULSE_LIMIT),
        .PROG_GUARD_CYC (PROG_GUARD_CYC),
        .ERASE_GUARD_CYC(ERASE_GUARD_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start     (op_start),
        .op_is_erase  (op_is_erase),
        .prog_msb     (prog_msb),
        .target_locked(target_locked),
        .erase_go     (erase_go),
        .op_done      (op_done),
        .rst_cmd      (rst_cmd),
        .state_q      (state_q),
        .accept       (accept),
        .erase_q      (erase_q),
        .msb_q        (msb_q)
    );

    opstat_tgl u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .active   (active),
        .rd_strobe(rd_strobe),
        .tgl_q    (tgl_q)
    );

    opstat_enc u_enc (
        .state_q   (state_q),
        .erase_q   (erase_q),
        .msb_q     (msb_q),
        .tgl_q     (tgl_q),
        .status_act(status_act),
        .status_q  (status_q)
    );

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[5] && !rst_cmd) |=> status_q[5]); // R7
    AST_STARTED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_act && status_q[3]) |=> (status_q[3] || !status_act)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !status_act |-> status_q == 8'h00); // R1
endmodule

// File: tb/opstat_reporter_test.sv
module opstat_reporter_test;
    localparam int PL = 40;
    localparam int PG = 16;
    localparam int EG = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 0, op_is_erase = 0, prog_msb = 0, target_locked = 0;
    logic       erase_go = 0, op_done = 0, rd_strobe = 0, rst_cmd = 0;
    logic       status_act;
    logic [7:0] status_q;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // model: 0 idle, 1 window, 2 prog, 3 erase, 4 guard, 5 fault
    int m_st = 0;
    int m_cnt = 0;
    bit m_tgl = 0, m_erase = 0, m_lock = 0, m_b7 = 0;

    always #4 clk = ~clk;

    opstat_reporter #(.PULSE_LIMIT(PL), .PROG_GUARD_CYC(PG), .ERASE_GUARD_CYC(EG)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .prog_msb(prog_msb), .target_locked(target_locked), .erase_go(erase_go),
        .op_done(op_done), .rd_strobe(rd_strobe), .rst_cmd(rst_cmd),
        .status_act(status_act), .status_q(status_q)
    );

    function automatic logic [7:0] exp_q();
        logic [7:0] v = 8'h00;
        if (m_st != 0) begin
            v[6] = m_tgl;
            if (m_st != 1) begin
                v[7] = m_erase ? 1'b0 : ~m_b7;
                v[5] = (m_st == 5);
                v[3] = m_erase;
            end
        end
        return v;
    endfunction

    function automatic string tag_of();
        case (m_st)
            0: return "R1 idle";
            1: return "R4 window";
            2: return "R2 program";
            3: return "R3 erase";
            4: return m_erase ? "R9 guard" : "R8 guard";
            default: return "R7 fault";
        endcase
    endfunction

    task automatic check(string tag, logic eact, logic [7:0] eq);
        vectors++;
        if (status_act !== eact || status_q !== eq) begin
            miscompares++;
            $display("FAIL %s: act=%b q=%h expected act=%b q=%h", tag, status_act, status_q, eact, eq);
        end
    endtask

    task automatic advance(bit s, bit e, bit b7, bit l, bit go, bit dn, bit rd, bit rc);
        case (m_st)
            0: if (s) begin
                m_b7 = b7; m_erase = e; m_lock = l; m_tgl = 0; m_cnt = 0;
                m_st = e ? 1 : (l ? 4 : 2);
            end
            1: begin
                m_tgl ^= rd;
                if (go) begin m_cnt = 0; m_st = m_lock ? 4 : 3; end
                else if (rc) m_st = 0;
            end
            2, 3: begin
                m_tgl ^= rd;
                if (dn) m_st = 0;
                else if (m_cnt == PL - 1) m_st = 5;
                else m_cnt++;
            end
            4: begin
                m_tgl ^= rd;
                if (m_cnt == (m_erase ? EG : PG) - 1) m_st = 0;
                else m_cnt++;
            end
            default: begin
                m_tgl ^= rd;
                if (rc) m_st = 0;
            end
        endcase
    endtask

    task automatic step(bit s, bit e, bit b7, bit l, bit go, bit dn, bit rd, bit rc, string tag);
        op_start = s; op_is_erase = e; prog_msb = b7; target_locked = l;
        erase_go = go; op_done = dn; rd_strobe = rd; rst_cmd = rc;
        @(posedge clk);
        #1;
        advance(s, e, b7, l, go, dn, rd, rc);
        check(tag == "" ? tag_of() : tag, m_st != 0, exp_q());
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: act=%b q=%h expected completion", status_act, status_q);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #4 rst_n = 1'b1;
        check("R1 reset state", 1'b0, 8'h00);

        // R2 program, R5 toggle, R10 ignores, R6 release
        step(1, 0, 0, 0, 0, 0, 0, 0, "R2 program start");
        check("R2 dq7 inverted", 1'b1, 8'h80);
        step(0, 0, 0, 0, 0, 0, 1, 0, "R5 toggle flips");
        check("R5 toggle value", 1'b1, 8'hC0);
        step(0, 0, 0, 0, 0, 0, 0, 0, "R5 toggle holds");
        step(1, 1, 1, 1, 0, 0, 0, 0, "R10 start ignored");
        check("R10 still program", 1'b1, 8'hC0);
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10 reset cmd ignored in program");
        step(0, 0, 0, 0, 0, 1, 1, 0, "R6 done releases");
        check("R6 released", 1'b0, 8'h00);

        // R6 collision: done on the cycle the limit would expire
        step(1, 0, 1, 0, 0, 0, 0, 0, "R2 program msb=1");
        check("R2 dq7 inverted of 1", 1'b1, 8'h00);
        idle(PL - 1, "");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R6 done beats limit");
        check("R6 done beats limit", 1'b0, 8'h00);

        // R7 fault
        step(1, 0, 0, 0, 0, 0, 0, 0, "");
        idle(PL, "");
        check("R7 fault flag", 1'b1, 8'hA0);
        step(0, 0, 0, 0, 0, 1, 1, 0, "R7 done ignored in fault");
        check("R7 fault still toggles", 1'b1, 8'hE0);
        step(0, 0, 0, 0, 0, 0, 0, 1, "R7 reset clears fault");
        check("R7 cleared", 1'b0, 8'h00);

        // R4 window, collision of go and reset cmd
        step(1, 1, 0, 0, 0, 0, 0, 0, "R4 window entered");
        check("R4 window bits", 1'b1, 8'h00);
        step(0, 0, 0, 0, 0, 0, 1, 0, "R4 window toggles");
        step(0, 0, 0, 0, 1, 0, 0, 1, "R4 go beats reset cmd");
        check("R3 erase bits", 1'b1, 8'h48);
        idle(5, "");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R6 erase done");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R4 window again");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R4 reset cmd aborts window");
        check("R4 aborted", 1'b0, 8'h00);

        // R8 protected program, R9 protected erase
        step(1, 0, 0, 1, 0, 0, 0, 0, "R8 guard start");
        for (int i = 0; i < PG; i++) step(0, 0, 0, 0, 0, 1, 0, 0, "R8 guard length");
        check("R8 guard over", 1'b0, 8'h00);
        step(1, 1, 0, 1, 0, 0, 0, 0, "R9 window");
        step(0, 0, 0, 0, 1, 0, 0, 0, "R9 guard start");
        check("R9 guard bits", 1'b1, 8'h08);
        idle(EG, "R9 guard length");
        check("R9 guard over", 1'b0, 8'h00);

        // random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) == 0, $urandom % 2, $urandom % 2, ($urandom % 5) == 0,
                 ($urandom % 10) == 0, ($urandom % 20) == 0, $urandom % 2,
                 ($urandom % 15) == 0, "");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule